// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block keeps the stack pointer of an 8-bit microcontroller core and turns each stack request into stack RAM addresses. The pointer is a low byte and a high byte. A configuration register chooses the width. With the widening bit clear, the pointer is one byte that wraps around inside 256 locations. With the bit set, the pointer is `ADDR_W` bits wide (11 by default), and the low byte carries into and borrows from the high byte.

The core gives a request code each cycle: a single-byte push, a single-byte pop, a two-byte call push or a two-byte return pop. One cycle later the unit reports the RAM address or addresses to use and whether they are writes. It also serves direct special-function-register reads and writes of the two pointer bytes and of the configuration register. The RAM, instruction decode and interrupt control are outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: After a synchronous reset the low byte is 07H, the high byte is 0 and the configuration register is 00H, so widening is off. The first push therefore addresses 08H.
- R2: Push code 1 increments the pointer first. It reports one write access at the new pointer value.
- R3: Pop code 2 reports one read access at the current pointer. It then decrements the pointer by one.
- R4: Call code 3 reports two writes: the first address is pointer+1 (low return byte) and the second is pointer+2 (high return byte). The pointer then advances by two. Return code 4 reports two reads: the first at the pointer (high byte) and the second at pointer-1 (low byte). The pointer then drops by two. Codes 0, 5, 6 and 7 do nothing.
- R5: With widening off, the pointer wraps from FFH to 00H on increment and from 00H to FFH on decrement. Reported address bits above bit 7 are zero.
- R6: With widening on, an increment from 00FFH gives 0100H, and a decrement from 0100H gives 00FFH.
- R7: With widening on, the pointer wraps from the all-ones value (7FFH) to 000H on increment, and back on decrement.
- R8: A read of the high-byte register (address B7H) returns the upper pointer bits in bits 2..0 and zeros in bits 7..3.
- R9: While widening is off, a write to the high-byte register has no effect and the register reads 0. Clearing the widening bit clears the high byte.
- R10: The configuration register (address AFH) holds the widening bit at bit 7 and the RAM-mapping enable at bit 0. The RAM-mapping enable appears on `xram_map_o`. Bits 6..1 read as 0.
- R11: A register write to a pointer byte (low byte at 81H) in the same cycle as a stack request wins: that byte takes the written value and the other byte keeps its old value. The access is still reported using the old pointer.
- R12: Access outputs and read data are registered and appear on the clock edge after the request. Read data shows register contents from before any write in that same cycle. When there is no access, all access outputs are 0. An unmapped read address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Stack request: 0 idle, 1 push, 2 pop, 3 call, 4 return |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address for read and write |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Registered read data for the address of the previous cycle |
| acc_valid_o | output | 1 | A stack access was requested on the previous cycle |
| acc_wr_o | output | 1 | The access writes RAM (push or call) |
| acc_dbl_o | output | 1 | The access covers two bytes (call or return) |
| acc_addr0_o | output | ADDR_W | First byte address |
| acc_addr1_o | output | ADDR_W | Second byte address, 0 for single-byte accesses |
| xram_map_o | output | 1 | RAM-mapping enable from the configuration register |

## Verification
The hardest state to reach is the edge of the widening switch. In that state, high pointer bits left from wide mode are still held while the widening bit has just been cleared. The very next request must ignore them, and the high byte must then read 0. The stimulus gets there by loading the high byte with widening on, clearing the bit, and then popping and reading back at once. Wrap points at 00FFH and 7FFH are reached by writing the pointer bytes directly. A long mixed run from a pseudo-random sequence then combines same-cycle writes with requests and mode changes. The bench model is compared with the design on every clock.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    STK_IDLE = 3'd0,
    STK_PUSH = 3'd1,
    STK_POP  = 3'd2,
    STK_CALL = 3'd3,
    STK_RET  = 3'd4
  } stkp_op_e;
endpackage

// File: rtl/stkp_cfg.sv
module stkp_cfg
  import stkp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              wide_en_o,
  output logic              xram_en_o,
  output logic [BYTE_W-1:0] cfg_byte_o
);
  logic wide_q, xram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= 1'b0;
      xram_q <= 1'b0;
    end else if (cfg_wr_i) begin
      wide_q <= wdata_i[BYTE_W-1];
      xram_q <= wdata_i[0];
    end
  end

  assign wide_en_o  = wide_q;
  assign xram_en_o  = xram_q;
  assign cfg_byte_o = {wide_q, {(BYTE_W-2){1'b0}}, xram_q};

  AST_CFG_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_byte_o[BYTE_W-2:1] == '0); // R10
endmodule

// File: rtl/stkp_core.sv
module stkp_core
  import stkp_pkg::*;
#(
  parameter int              ADDR_W = 11,
  parameter logic [BYTE_W-1:0] RST_LO = 8'h07
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_en_i,
  input  logic [2:0]        op_i,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [ADDR_W-BYTE_W-1:0] hi_o,
  output logic              acc_valid_o,
  output logic              acc_wr_o,
  output logic              acc_dbl_o,
  output logic [ADDR_W-1:0] acc_addr0_o,
  output logic [ADDR_W-1:0] acc_addr1_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] eff, inc1, inc2, dec1, dec2;
  logic [ADDR_W-1:0] nxt, a0, a1;
  logic              v, w, d;
  stkp_op_e          op;

  function automatic logic [ADDR_W-1:0] fold(input logic [ADDR_W-1:0] val,
                                             input logic wide);
    fold = wide ? val : {{HI_W{1'b0}}, val[BYTE_W-1:0]};
  endfunction

  assign op   = stkp_op_e'(op_i);
  assign eff  = fold({hi_q, lo_q}, wide_en_i);
  assign inc1 = fold(eff + ADDR_W'(1), wide_en_i);
  assign inc2 = fold(eff + ADDR_W'(2), wide_en_i);
  assign dec1 = fold(eff - ADDR_W'(1), wide_en_i);
  assign dec2 = fold(eff - ADDR_W'(2), wide_en_i);

  always_comb begin
    nxt = eff;
    a0  = '0;
    a1  = '0;
    v   = 1'b0;
    w   = 1'b0;
    d   = 1'b0;
    case (op)
      STK_PUSH: begin nxt = inc1; a0 = inc1; v = 1'b1; w = 1'b1; end
      STK_POP:  begin nxt = dec1; a0 = eff;  v = 1'b1; end
      STK_CALL: begin nxt = inc2; a0 = inc1; a1 = inc2; v = 1'b1; w = 1'b1; d = 1'b1; end
      STK_RET:  begin nxt = dec2; a0 = eff;  a1 = dec1; v = 1'b1; d = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q        <= RST_LO;
      hi_q        <= '0;
      acc_valid_o <= 1'b0;
      acc_wr_o    <= 1'b0;
      acc_dbl_o   <= 1'b0;
      acc_addr0_o <= '0;
      acc_addr1_o <= '0;
    end else begin
      if (lo_wr_i)      lo_q <= wdata_i;
      else if (hi_wr_i) lo_q <= lo_q;
      else              lo_q <= nxt[BYTE_W-1:0];

      if (!wide_en_i)   hi_q <= '0;
      else if (hi_wr_i) hi_q <= wdata_i[HI_W-1:0];
      else if (lo_wr_i) hi_q <= hi_q;
      else              hi_q <= nxt[ADDR_W-1:BYTE_W];

      acc_valid_o <= v;
      acc_wr_o    <= w;
      acc_dbl_o   <= d;
      acc_addr0_o <= a0;
      acc_addr1_o <= a1;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lo_q == RST_LO && hi_q == '0)); // R1
  AST_PUSH_TRACKS_PTR: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH && !lo_wr_i && !hi_wr_i) |=>
      (wide_en_i != $past(wide_en_i)) || (acc_addr0_o == eff)); // R2
  AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    (acc_dbl_o && acc_wr_o) |->
      acc_addr1_o == fold(acc_addr0_o + ADDR_W'(1), $past(wide_en_i))); // R4
  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_o && !$past(wide_en_i)) |->
      (acc_addr0_o[ADDR_W-1:BYTE_W] == '0 && acc_addr1_o[ADDR_W-1:BYTE_W] == '0)); // R5
  AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wide_en_i |=> hi_q == '0); // R9
  AST_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    lo_wr_i |=> lo_q == $past(wdata_i)); // R11
endmodule

// File: rtl/stkp_rdmux.sv
module stkp_rdmux
  import stkp_pkg::*;
#(
  parameter int              HI_W    = 3,
  parameter logic [BYTE_W-1:0] LO_ADR  = 8'h81,
  parameter logic [BYTE_W-1:0] HI_ADR  = 8'hB7,
  parameter logic [BYTE_W-1:0] CFG_ADR = 8'hAF
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              wide_en_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [BYTE_W-1:0] cfg_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr_i == LO_ADR)       sel = lo_i;
    else if (addr_i == HI_ADR)  sel = wide_en_i ? {{(BYTE_W-HI_W){1'b0}}, hi_i} : '0;
    else if (addr_i == CFG_ADR) sel = cfg_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= sel;
  end

  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr_i == HI_ADR) |=> rdata_o[BYTE_W-1:HI_W] == '0); // R8
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stkp_pkg::*;
#(
  parameter int              ADDR_W  = 11,
  parameter logic [7:0]      RST_LO  = 8'h07,
  parameter logic [7:0]      LO_ADR  = 8'h81,
  parameter logic [7:0]      HI_ADR  = 8'hB7,
  parameter logic [7:0]      CFG_ADR = 8'hAF
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic              sfr_wr_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  output logic              acc_valid_o,
  output logic              acc_wr_o,
  output logic              acc_dbl_o,
  output logic [ADDR_W-1:0] acc_addr0_o,
  output logic [ADDR_W-1:0] acc_addr1_o,
  output logic              xram_map_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic              wide_en;
  logic [BYTE_W-1:0] cfg_byte;
  logic [BYTE_W-1:0] lo;
  logic [HI_W-1:0]   hi;
  logic              cfg_wr, lo_wr, hi_wr;

  assign cfg_wr = sfr_wr_i && (sfr_addr_i == CFG_ADR);
  assign lo_wr  = sfr_wr_i && (sfr_addr_i == LO_ADR);
  assign hi_wr  = sfr_wr_i && (sfr_addr_i == HI_ADR) && wide_en;

  stkp_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr_i   (cfg_wr),
    .wdata_i    (sfr_wdata_i),
    .wide_en_o  (wide_en),
    .xram_en_o  (xram_map_o),
    .cfg_byte_o (cfg_byte)
  );

  stkp_core #(.ADDR_W(ADDR_W), .RST_LO(RST_LO)) u_core (
    .clk         (clk),
    .rst         (rst),
    .wide_en_i   (wide_en),
    .op_i        (op_i),
    .lo_wr_i     (lo_wr),
    .hi_wr_i     (hi_wr),
    .wdata_i     (sfr_wdata_i),
    .lo_o        (lo),
    .hi_o        (hi),
    .acc_valid_o (acc_valid_o),
    .acc_wr_o    (acc_wr_o),
    .acc_dbl_o   (acc_dbl_o),
    .acc_addr0_o (acc_addr0_o),
    .acc_addr1_o (acc_addr1_o)
  );

  stkp_rdmux #(.HI_W(HI_W), .LO_ADR(LO_ADR), .HI_ADR(HI_ADR), .CFG_ADR(CFG_ADR)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (sfr_addr_i),
    .wide_en_i (wide_en),
    .lo_i      (lo),
    .hi_i      (hi),
    .cfg_i     (cfg_byte),
    .rdata_o   (sfr_rdata_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid_o |-> (!acc_wr_o && !acc_dbl_o && acc_addr0_o == '0 && acc_addr1_o == '0)); // R12
endmodule

// File: tb/stack_ptr_unit_tb_top.sv
module stack_ptr_unit_tb_top;
  localparam int ADDR_W = 11;
  localparam int LO_A = 8'h81, HI_A = 8'hB7, CFG_A = 8'hAF;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        op_i = '0;
  logic              sfr_wr_i = 1'b0;
  logic [7:0]        sfr_addr_i = '0;
  logic [7:0]        sfr_wdata_i = '0;
  logic [7:0]        sfr_rdata_o;
  logic              acc_valid_o, acc_wr_o, acc_dbl_o, xram_map_o;
  logic [ADDR_W-1:0] acc_addr0_o, acc_addr1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_sp, m_wide, m_xram;

  always #5 clk = ~clk;

  stack_ptr_unit dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .sfr_wr_i(sfr_wr_i),
    .sfr_addr_i(sfr_addr_i), .sfr_wdata_i(sfr_wdata_i),
    .sfr_rdata_o(sfr_rdata_o), .acc_valid_o(acc_valid_o),
    .acc_wr_o(acc_wr_o), .acc_dbl_o(acc_dbl_o),
    .acc_addr0_o(acc_addr0_o), .acc_addr1_o(acc_addr1_o),
    .xram_map_o(xram_map_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(input int op, input bit wr, input int adr, input int dat, input string tag);
    int mask, base, nsp, a0, a1, v, w, d, rd;
    mask = m_wide ? 2047 : 255;
    base = m_sp & mask;
    nsp = base; a0 = 0; a1 = 0; v = 0; w = 0; d = 0;
    case (op)
      1: begin a0 = (base + 1) & mask; nsp = a0; v = 1; w = 1; end
      2: begin a0 = base; nsp = (base + 2047) & mask; v = 1; end
      3: begin a0 = (base + 1) & mask; a1 = (base + 2) & mask; nsp = a1; v = 1; w = 1; d = 1; end
      4: begin a0 = base; a1 = (base + 2047) & mask; nsp = (base + 2046) & mask; v = 1; d = 1; end
      default: ;
    endcase
    rd = 0;
    if (adr == LO_A) rd = base & 255;
    else if (adr == HI_A) rd = m_wide ? (base >> 8) & 7 : 0;
    else if (adr == CFG_A) rd = (m_wide << 7) | m_xram;
    if (wr && adr == LO_A) nsp = (base & 16'h700) | (dat & 255);
    if (wr && adr == HI_A && m_wide) nsp = ((dat & 7) << 8) | (base & 255);
    if (!m_wide) nsp = nsp & 255;
    m_sp = nsp;
    if (wr && adr == CFG_A) begin m_wide = (dat >> 7) & 1; m_xram = dat & 1; end

    op_i = op[2:0]; sfr_wr_i = wr; sfr_addr_i = adr[7:0]; sfr_wdata_i = dat[7:0];
    @(posedge clk);
    @(negedge clk);
    chk(tag, "valid", int'(acc_valid_o), v);
    chk(tag, "wr",    int'(acc_wr_o), w);
    chk(tag, "dbl",   int'(acc_dbl_o), d);
    chk(tag, "addr0", int'(acc_addr0_o), a0);
    chk(tag, "addr1", int'(acc_addr1_o), a1);
    chk(tag, "rdata", int'(sfr_rdata_o), rd);
    chk(tag, "xram",  int'(xram_map_o), m_xram);
  endtask

  task automatic idle(input int adr, input string tag);
    cyc(0, 1'b0, adr, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_sp = 7; m_wide = 0; m_xram = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state of outputs and registers
    chk("R1", "valid after reset", int'(acc_valid_o), 0);
    chk("R1", "rdata after reset", int'(sfr_rdata_o), 0);
    idle(LO_A, "R1");
    idle(CFG_A, "R1");
    idle(HI_A, "R1");
    cyc(1, 0, 0, 0, "R1");          // first push at 08H
    cyc(1, 0, 0, 0, "R2");
    cyc(2, 0, 0, 0, "R3");
    cyc(2, 0, LO_A, 0, "R3");
    idle(LO_A, "R3");
    cyc(3, 0, 0, 0, "R4");
    cyc(4, 0, LO_A, 0, "R4");
    cyc(5, 0, 0, 0, "R4");          // unused codes do nothing
    cyc(7, 0, LO_A, 0, "R4");
    // R5: narrow wrap both ways
    cyc(0, 1, LO_A, 8'hFF, "R5");
    cyc(1, 0, 0, 0, "R5");
    cyc(2, 0, 0, 0, "R5");
    cyc(0, 1, LO_A, 8'hFE, "R5");
    cyc(3, 0, 0, 0, "R5");
    cyc(4, 0, LO_A, 0, "R5");
    // R9: high byte ignored while narrow
    cyc(0, 1, HI_A, 8'h05, "R9");
    idle(HI_A, "R9");
    cyc(2, 0, HI_A, 0, "R9");
    // R10: configuration register
    cyc(0, 1, CFG_A, 8'hFF, "R10");
    idle(CFG_A, "R10");
    cyc(0, 1, CFG_A, 8'h80, "R10");
    idle(CFG_A, "R10");
    // R6: carry and borrow
    cyc(0, 1, HI_A, 8'h00, "R6");
    cyc(0, 1, LO_A, 8'hFF, "R6");
    cyc(1, 0, HI_A, 0, "R6");
    idle(HI_A, "R6");
    cyc(2, 0, LO_A, 0, "R6");
    idle(HI_A, "R6");
    // R7: top wrap
    cyc(0, 1, HI_A, 8'hFF, "R7");
    idle(HI_A, "R8");               // bits 7..3 read zero
    cyc(0, 1, LO_A, 8'hFF, "R7");
    cyc(1, 0, 0, 0, "R7");
    cyc(2, 0, HI_A, 0, "R7");
    cyc(0, 1, LO_A, 8'hFE, "R7");
    cyc(3, 0, 0, 0, "R7");
    cyc(4, 0, HI_A, 0, "R7");
    cyc(0, 1, LO_A, 8'h00, "R7");
    cyc(0, 1, HI_A, 8'h00, "R7");
    cyc(4, 0, 0, 0, "R7");
    // R11: same-cycle write priority
    cyc(0, 1, HI_A, 8'h02, "R11");
    cyc(1, 1, LO_A, 8'h40, "R11");
    idle(LO_A, "R11");
    cyc(2, 1, HI_A, 8'h01, "R11");
    idle(HI_A, "R11");
    cyc(3, 1, LO_A, 8'h10, "R11");
    idle(LO_A, "R11");
    // R9: leaving wide mode with upper bits set
    cyc(0, 1, HI_A, 8'h06, "R9");
    cyc(0, 1, CFG_A, 8'h01, "R9");
    cyc(2, 0, HI_A, 0, "R9");
    idle(HI_A, "R9");
    cyc(0, 1, CFG_A, 8'h80, "R9");
    idle(HI_A, "R9");
    // R12: long mixed run
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      int op, adr, wr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[2:0];
      case (lfsr[5:4])
        2'd0: adr = LO_A;
        2'd1: adr = HI_A;
        2'd2: adr = CFG_A;
        default: adr = 8'h55;
      endcase
      wr = (lfsr[9:7] == 3'd0);
      cyc(op, wr[0], adr, lfsr[15:8], "R12");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule